// File: doc/BRIEF.md
# Serial Bus Frame Encoder

This block turns a frame held in a byte-wide memory into a serial bit stream for an automotive-style bus. A start pulse, or an internal repeat timer, launches a transmission. The block drives a low start sequence on the line, then a single high start-of-frame bit. After that it sends each stored byte, with a two-bit marker (high, then low) in front of every byte and the data bits sent most significant first. A low-then-high end sequence closes the frame, and the line then goes back to idle high.

Bytes are read one at a time through a read port with one cycle of latency. Each read is issued at the start of the marker that comes before its byte, so the line never stalls waiting on memory. Bit timing comes from the system clock: each bit lasts a parameterised number of clock cycles, 8 by default, which gives 6.25 Mbit/s from a 50 MHz clock. Any header or trailer check values must already be in memory. The block sends bytes exactly as stored.

Top module: `serial_frame_encoder`

## Requirements
- R1: Out of reset, `tx_o` is high, `busy_o`, `done_o` and `mem_rd_o` are low, and `tx_o` stays high whenever `busy_o` is low.
- R2: A `start_i` pulse seen while idle is accepted at that clock edge. `busy_o` is high in the following cycle, and `tx_o` is driven low for `TSS_BITS` bit times (default 5). Every bit lasts `CLK_PER_BIT` cycles.
- R3: Right after the low start sequence, one high bit time marks the start of the frame.
- R4: Every data byte is preceded by a two-bit marker: one high bit, then one low bit.
- R5: Byte k is read from address k, for k = 0 to length-1 in increasing order, with exactly one read per byte. Its eight bits go out most significant bit first.
- R6: After the last byte, the line is low for one bit time and then high for one bit time, and stays high afterwards.
- R7: `busy_o` stays high through the last end-sequence bit. `done_o` is high for exactly one cycle, the first cycle in which `busy_o` is low again.
- R8: While `busy_o` is high, `start_i` and changes on `frame_len_i` have no effect: the frame in progress is unchanged and no new frame follows it.
- R9: A frame length of 0 sends only the start sequence, the start-of-frame bit and the end sequence, with no memory read.
- R10: With no `start_i`, a new frame is accepted `REPEAT_CYCLES` clock cycles after the previous acceptance, if the block is idle at that point.
- R11: The memory returns `mem_data_i` in the cycle after a `mem_rd_o` pulse. That data is the byte sent, and each `mem_rd_o` pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to send one frame |
| frame_len_i | input | ADDR_W+1 | Number of data bytes, sampled when a start is accepted |
| mem_rd_o | output | 1 | One-cycle memory read strobe |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_data_i | input | 8 | Read data, valid the cycle after the strobe |
| tx_o | output | 1 | Serial line, idle high |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse when the line returns to idle |

## Verification
The line is sampled at the middle of every bit time, and each symbol and byte is rebuilt and compared with the memory contents. Frames are sent with lengths 0, 1, 3 and 4, and with counting, alternating 0xAA/0x55 and 0x00/0xFF byte patterns. A wrong bit order, a shifted bit slot or a fetch that lands one cycle late each produce different wrong bytes under these patterns. The zero-length frame shows that the end sequence is reached without a read. A start pulse and a length change injected in the middle of a byte check that a running frame cannot be disturbed. An untouched idle period measures the repeat interval to the exact cycle.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    typedef enum logic [2:0] {
        SYM_IDLE,
        SYM_TSS,
        SYM_FSS,
        SYM_BSS_HI,
        SYM_BSS_LO,
        SYM_DATA,
        SYM_FES_LO,
        SYM_FES_HI
    } sym_e;

    // position inside the running symbol: which bit of it is on the line
    typedef struct packed {
        sym_e       sym;
        logic [3:0] pos;
    } slot_t;

    localparam int BYTE_BITS = 8;

    function automatic logic line_level(input sym_e s, input logic data_bit);
        case (s)
            SYM_TSS, SYM_BSS_LO, SYM_FES_LO: line_level = 1'b0;
            SYM_DATA:                        line_level = data_bit;
            default:                         line_level = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/sfe_bit_timer.sv
module sfe_bit_timer #(
    parameter int CLK_PER_BIT = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clear_i,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (CLK_PER_BIT > 2) ? $clog2(CLK_PER_BIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_PER_BIT - 1);

    logic [CW-1:0] cnt;

    assign tick_o = run_i && (cnt == LAST);

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i || !run_i) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sfe_repeat_timer.sv
module sfe_repeat_timer #(
    parameter int unsigned INTERVAL = 250_000_000
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic restart_i,
    output logic fire_o
);
    localparam int CW = $clog2(INTERVAL + 1);
    localparam logic [CW-1:0] LIMIT = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt;

    assign fire_o = (cnt == LIMIT);

    always_ff @(posedge clk_i) begin
        if (rst_i || restart_i) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sfe_fetch.sv
module sfe_fetch #(
    parameter int ADDR_W = 9
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [7:0]        mem_data_i,
    output logic [7:0]        byte_o
);
    logic rd_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mem_rd_o   <= 1'b0;
            mem_addr_o <= '0;
            rd_q       <= 1'b0;
            byte_o     <= '0;
        end else begin
            mem_rd_o <= req_i;
            rd_q     <= mem_rd_o;
            if (req_i) mem_addr_o <= req_addr_i;
            if (rd_q)  byte_o     <= mem_data_i;
        end
    end
endmodule

// File: rtl/sfe_sequencer.sv
module sfe_sequencer
    import sfe_pkg::*;
#(
    parameter int TSS_BITS = 5,
    parameter int ADDR_W   = 9
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              accept_i,
    input  logic [ADDR_W:0]   len_i,
    input  logic              tick_i,
    input  logic [7:0]        byte_i,
    output logic              req_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic              tx_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int LEN_W = ADDR_W + 1;
    localparam logic [3:0] TSS_LAST  = 4'(TSS_BITS - 1);
    localparam logic [3:0] BYTE_LAST = 4'(BYTE_BITS - 1);

    slot_t            slot_q, slot_n;
    logic [LEN_W-1:0] idx_q, idx_n, len_q, idx_inc;
    logic [7:0]       sh_q, sh_n;
    logic             done_n;

    assign idx_inc = idx_q + LEN_W'(1);
    assign busy_o  = (slot_q.sym != SYM_IDLE);

    always_comb begin
        slot_n     = slot_q;
        idx_n      = idx_q;
        sh_n       = sh_q;
        req_o      = 1'b0;
        req_addr_o = '0;
        done_n     = 1'b0;
        if (accept_i && slot_q.sym == SYM_IDLE) begin
            slot_n = '{sym: SYM_TSS, pos: 4'd0};
            idx_n  = '0;
        end else if (tick_i) begin
            case (slot_q.sym)
                SYM_TSS: begin
                    if (slot_q.pos == TSS_LAST) slot_n = '{sym: SYM_FSS, pos: 4'd0};
                    else                        slot_n.pos = slot_q.pos + 4'd1;
                end
                SYM_FSS: begin
                    if (len_q == '0) begin
                        slot_n = '{sym: SYM_FES_LO, pos: 4'd0};
                    end else begin
                        slot_n = '{sym: SYM_BSS_HI, pos: 4'd0};
                        req_o  = 1'b1;
                    end
                end
                SYM_BSS_HI: slot_n = '{sym: SYM_BSS_LO, pos: 4'd0};
                SYM_BSS_LO: begin
                    slot_n = '{sym: SYM_DATA, pos: 4'd0};
                    sh_n   = byte_i;
                end
                SYM_DATA: begin
                    if (slot_q.pos == BYTE_LAST) begin
                        idx_n = idx_inc;
                        if (idx_inc == len_q) begin
                            slot_n = '{sym: SYM_FES_LO, pos: 4'd0};
                        end else begin
                            slot_n     = '{sym: SYM_BSS_HI, pos: 4'd0};
                            req_o      = 1'b1;
                            req_addr_o = idx_inc[ADDR_W-1:0];
                        end
                    end else begin
                        slot_n.pos = slot_q.pos + 4'd1;
                        sh_n       = {sh_q[6:0], 1'b0};
                    end
                end
                SYM_FES_LO: slot_n = '{sym: SYM_FES_HI, pos: 4'd0};
                SYM_FES_HI: begin
                    slot_n = '{sym: SYM_IDLE, pos: 4'd0};
                    done_n = 1'b1;
                end
                default: slot_n = '{sym: SYM_IDLE, pos: 4'd0};
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            slot_q <= '{sym: SYM_IDLE, pos: 4'd0};
            idx_q  <= '0;
            len_q  <= '0;
            sh_q   <= '0;
            tx_o   <= 1'b1;
            done_o <= 1'b0;
        end else begin
            slot_q <= slot_n;
            idx_q  <= idx_n;
            sh_q   <= sh_n;
            tx_o   <= line_level(slot_n.sym, sh_n[7]);
            done_o <= done_n;
            if (accept_i && slot_q.sym == SYM_IDLE) len_q <= len_i;
        end
    end
endmodule

// File: rtl/serial_frame_encoder.sv
module serial_frame_encoder #(
    parameter int          CLK_PER_BIT   = 8,
    parameter int          TSS_BITS      = 5,
    parameter int          ADDR_W        = 9,
    parameter int unsigned REPEAT_CYCLES = 250_000_000
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic [ADDR_W:0]   frame_len_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [7:0]        mem_data_i,
    output logic              tx_o,
    output logic              busy_o,
    output logic              done_o
);
    logic              accept, tick, fire, req;
    logic [ADDR_W-1:0] req_addr;
    logic [7:0]        fetched;

    assign accept = (start_i || fire) && !busy_o;

    sfe_repeat_timer #(.INTERVAL(REPEAT_CYCLES)) u_rep (
        .clk_i(clk_i), .rst_i(rst_i), .restart_i(accept), .fire_o(fire)
    );

    sfe_bit_timer #(.CLK_PER_BIT(CLK_PER_BIT)) u_bit (
        .clk_i(clk_i), .rst_i(rst_i), .clear_i(accept), .run_i(busy_o), .tick_o(tick)
    );

    sfe_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk_i(clk_i), .rst_i(rst_i), .req_i(req), .req_addr_i(req_addr),
        .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
        .byte_o(fetched)
    );

    sfe_sequencer #(.TSS_BITS(TSS_BITS), .ADDR_W(ADDR_W)) u_seq (
        .clk_i(clk_i), .rst_i(rst_i), .accept_i(accept), .len_i(frame_len_i),
        .tick_i(tick), .byte_i(fetched), .req_o(req), .req_addr_o(req_addr),
        .tx_o(tx_o), .busy_o(busy_o), .done_o(done_o)
    );
endmodule

// File: rtl/sfe_checker.sv
module sfe_checker (
    input logic clk_i,
    input logic rst_i,
    input logic start_i,
    input logic tx_o,
    input logic busy_o,
    input logic done_o,
    input logic mem_rd_o
);
    p_idle_line_high_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        !busy_o |-> tx_o);

    p_start_accepted_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (start_i && !busy_o) |=> busy_o);

    p_tss_begins_low_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(busy_o) |-> !tx_o);

    p_done_single_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |=> !done_o);

    p_done_on_busy_fall_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(busy_o) |-> done_o);

    p_done_when_idle_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        done_o |-> !busy_o);

    p_read_inside_frame_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        mem_rd_o |-> busy_o);

    p_read_one_cycle_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        mem_rd_o |=> !mem_rd_o);
endmodule

bind serial_frame_encoder sfe_checker u_chk (
    .clk_i(clk_i), .rst_i(rst_i), .start_i(start_i), .tx_o(tx_o),
    .busy_o(busy_o), .done_o(done_o), .mem_rd_o(mem_rd_o)
);

// File: tb/sim_serial_frame_encoder.sv
module sim_serial_frame_encoder;
    localparam int CLK_PERIOD = 10;
    localparam int CPB        = 8;
    localparam int TSS        = 5;
    localparam int AW         = 9;
    localparam int REP        = 3000;
    localparam int RAM_N      = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW:0]   flen = '0;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_q = '0;
    logic          tx, busy, done;

    logic [7:0] ram [0:RAM_N-1];
    int tests = 0, fails = 0;
    int cyc = 0, rd_count = 0, rd_bad = 0;
    int rise_n = 0, rise_last = 0, rise_prev = 0;
    logic busy_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_frame_encoder #(.CLK_PER_BIT(CPB), .TSS_BITS(TSS), .ADDR_W(AW),
                           .REPEAT_CYCLES(REP)) u0 (
        .clk_i(clk), .rst_i(rst), .start_i(start), .frame_len_i(flen),
        .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_data_i(mem_q),
        .tx_o(tx), .busy_o(busy), .done_o(done)
    );

    // one-cycle-latency memory model
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd) mem_q <= ram[mem_addr];
    end

    always @(negedge clk) begin
        if (mem_rd) begin
            if (int'(mem_addr) != rd_count) rd_bad++;
            rd_count++;
        end
        if (busy && !busy_prev) begin
            rise_prev = rise_last;
            rise_last = cyc;
            rise_n++;
        end
        busy_prev = busy;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic fill(input int pat);
        for (int i = 0; i < RAM_N; i++) begin
            case (pat)
                0: ram[i] = 8'(i * 7 + 3);
                1: ram[i] = (i % 2 == 0) ? 8'hAA : 8'h55;
                2: ram[i] = (i % 2 == 0) ? 8'h00 : 8'hFF;
                default: ram[i] = 8'(i) ^ 8'hC3;
            endcase
        end
    endtask

    // advance one bit time; optionally inject a start and a new length mid-frame
    task automatic step_bit(input bit poke, input int poke_len, output logic b);
        for (int i = 0; i < CPB; i++) begin
            @(negedge clk);
            if (poke && i == 0) begin start = 1'b1; flen = (AW+1)'(poke_len); end
            if (poke && i == 1) start = 1'b0;
        end
        b = tx;
    endtask

    task automatic send_and_check(input string name, input int len, input bit poke);
        logic b;
        int bad;
        logic [7:0] got;
        rd_count = 0;
        rd_bad   = 0;
        @(negedge clk);
        flen  = (AW+1)'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R2", {name, " busy after start"}, int'(busy), 1);
        repeat (CPB/2) @(negedge clk);
        bad = 0;
        if (tx !== 1'b0) bad++;
        for (int i = 1; i < TSS; i++) begin
            step_bit(1'b0, 0, b);
            if (b !== 1'b0) bad++;
        end
        check(bad == 0, "R2", {name, " start sequence low bits wrong"}, bad, 0);
        step_bit(1'b0, 0, b);
        check(b === 1'b1, "R3", {name, " start-of-frame bit"}, int'(b), 1);
        for (int k = 0; k < len; k++) begin
            logic hi, lo;
            step_bit(1'b0, 0, hi);
            step_bit(1'b0, 0, lo);
            check(hi === 1'b1 && lo === 1'b0, "R4", {name, " byte marker (hi*2+lo)"},
                  int'({hi, lo}), 2);
            got = '0;
            for (int j = 0; j < 8; j++) begin
                step_bit(poke && k == 0 && j == 3, len + 3, b);
                got = {got[6:0], b};
            end
            check(got === ram[k], "R5/R11", {name, " data byte"}, int'(got), int'(ram[k]));
        end
        step_bit(1'b0, 0, b);
        check(b === 1'b0, "R6", {name, " end sequence low bit"}, int'(b), 0);
        step_bit(1'b0, 0, b);
        check(b === 1'b1 && busy === 1'b1, "R6/R7", {name, " end high bit with busy"},
              int'({b, busy}), 3);
        repeat (CPB/2) @(negedge clk);
        check(done === 1'b1 && busy === 1'b0 && tx === 1'b1, "R7",
              {name, " done/busy/tx at return to idle"}, int'({done, busy, tx}), 5);
        @(negedge clk);
        check(done === 1'b0, "R7", {name, " done lasts one cycle"}, int'(done), 0);
        check(rd_count == len && rd_bad == 0, "R5", {name, " read count, order errors"},
              rd_count * 1000 + rd_bad, len * 1000);
        flen = (AW+1)'(len);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(tx === 1'b1 && busy === 1'b0 && done === 1'b0 && mem_rd === 1'b0, "R1",
              "reset state tx,busy,done,rd", int'({tx, busy, done, mem_rd}), 8);
    endtask

    task automatic t_frames();
        fill(0); send_and_check("count len1", 1, 1'b0);
        fill(1); send_and_check("alt len4", 4, 1'b0);
        fill(2); send_and_check("ff00 len3", 3, 1'b0);
        fill(3); send_and_check("xor len4", 4, 1'b0);
    endtask

    task automatic t_zero_len();
        fill(0);
        send_and_check("len0 R9", 0, 1'b0);
    endtask

    task automatic t_busy_ignore();
        int bad = 0;
        fill(1);
        send_and_check("poke len2 R8", 2, 1'b1);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (busy !== 1'b0 || tx !== 1'b1) bad++;
        end
        check(bad == 0, "R8", "no frame after ignored start", bad, 0);
    endtask

    task automatic t_auto();
        int n0, waited = 0;
        fill(3);
        send_and_check("auto seed", 2, 1'b0);
        n0 = rise_n;
        while (rise_n == n0 && waited < 2 * REP) begin
            @(negedge clk);
            waited++;
        end
        check(rise_n == n0 + 1 && rise_last - rise_prev == REP, "R10",
              "repeat interval in cycles", rise_last - rise_prev, REP);
        waited = 0;
        while (busy && waited < 2000) begin
            @(negedge clk);
            waited++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_frames();
        t_zero_len();
        t_busy_ignore();
        t_auto();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule